// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block cleans up the digital input lines of a multi-port input block before they are used. Each raw input bit first crosses into the clock domain through a two-flop synchronizer. A bit that is selected for filtering then moves its output to a new level only after the synchronized level has stayed different from the output for a programmed number of filter ticks. A tick is a fixed 200 ns time base derived from the clock by a prescaler.

One interval value applies to every port. A per-bit enable mask, one byte per port, decides which bits go through the filter. Bits that are not selected, and all bits while the interval is zero, pass the synchronized level straight to the output. A level that reverts before the count completes clears that bit's counter, so short pulses and bursts of chatter never reach the output. The interval and the mask come from the surrounding register bank as plain inputs; edge detection sits after this block.

Top module: `input_glitch_filter`

## Requirements
- R1: While reset is asserted, and on the first sample after reset, `filtOut` is all zeros, whatever `rawIn` carries.
- R2: Each raw bit goes through two synchronizing flops and one output flop. A bit whose enable bit is 0 shows on `filtOut` the `rawIn` level sampled three clock edges earlier.
- R3: When `cfgInterval` is zero, every bit behaves as in R2, whatever `cfgMask` holds.
- R4: A tick occurs once every `TICK_DIV` clock cycles (10 by default, 200 ns at 50 MHz). A filtered bit with interval N takes its new level after N ticks with the changed level. Counting clock edges from the `rawIn` change, the output changes no earlier than edge 3+(N-1)·TICK_DIV and no later than edge 2+N·TICK_DIV.
- R5: A filtered bit's output changes only at a tick edge, and only to the synchronized level present at that edge.
- R6: For N of 2 or more, a pulse on a filtered bit that lasts (N-1)·TICK_DIV cycles or less leaves the output unchanged.
- R7: A filtered bit that returns to its output level for even one cycle restarts its count. A steady change that follows then needs the full R4 latency, measured from its own start.
- R8: Bits are filtered independently. A bit held in its filter window does not delay or alter any other bit.
- R9: Bit i of `cfgMask` controls bit i of `rawIn` and `filtOut`. Port p occupies bits 8p+7 down to 8p. The single 20-bit interval (maximum 0xFFFFF ticks) applies to every port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the tick prescaler runs from it |
| rstN | input | 1 | Active-low synchronous reset |
| rawIn | input | NUM_PORTS*8 | Asynchronous raw input bits |
| cfgInterval | input | 20 | Filter interval in ticks, shared by all ports; 0 bypasses filtering |
| cfgMask | input | NUM_PORTS*8 | Per-bit filter enable, 1 = filtered |
| filtOut | output | NUM_PORTS*8 | Filtered input bits |

## Verification
Every bit of every port is driven one at a time in three settings: interval zero with all bits enabled, a nonzero interval with only that bit left unmasked, and intervals of one to three ticks with only that bit enabled. These runs separate the bypass paths from the counting path and expose any bit-position or port mix-up. For the counting path, the latency is measured against a window one tick wide, because the prescaler phase is free-running. A pulse just short of the interval must never appear at the output. A pulse followed by a one-cycle return and then a steady change must still take the full latency, which shows whether the counter really restarts. A filtered bit and an unmasked bit in another port switch together to show that the bits do not affect each other.

// File: rtl/glitch_filter_pkg.sv
package glitch_filter_pkg;
  localparam int PORT_BITS = 8;
  localparam int IVL_W     = 20;

  typedef struct packed {
    logic tick;       // one-cycle strobe, one per filter time unit
    logic bypassAll;  // interval programmed to zero
  } gf_strobe_t;
endpackage

// File: rtl/glitch_filter_ctrl.sv
module glitch_filter_ctrl
  import glitch_filter_pkg::*;
#(
  parameter int TICK_DIV = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IVL_W-1:0] cfgInterval,
  output gf_strobe_t       strobe
);
  logic tickRaw;

  generate
    if (TICK_DIV <= 1) begin : g_noDiv
      assign tickRaw = 1'b1;
    end else begin : g_div
      localparam int DIV_W = $clog2(TICK_DIV);
      localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);
      logic [DIV_W-1:0] divCnt;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          divCnt <= '0;
        end else if (divCnt == LAST) begin
          divCnt <= '0;
        end else begin
          divCnt <= divCnt + DIV_W'(1);
        end
      end

      assign tickRaw = (divCnt == LAST);
    end
  endgenerate

  always_comb begin
    strobe.tick      = tickRaw;
    strobe.bypassAll = (cfgInterval == '0);
  end
endmodule

// File: rtl/glitch_filter_datapath.sv
module glitch_filter_datapath
  import glitch_filter_pkg::*;
#(
  parameter int BITS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BITS-1:0]  rawIn,
  input  logic [BITS-1:0]  cfgMask,
  input  logic [IVL_W-1:0] cfgInterval,
  input  gf_strobe_t       strobe,
  output logic [BITS-1:0]  syncQ,
  output logic [BITS-1:0]  filtOut
);
  localparam int CMP_W = IVL_W + 1;

  logic [BITS-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      meta  <= '0;
      syncQ <= '0;
    end else begin
      meta  <= rawIn;
      syncQ <= meta;
    end
  end

  generate
    for (genvar i = 0; i < BITS; i++) begin : g_bit
      logic [IVL_W-1:0] runCnt;
      logic             levelQ;
      logic [CMP_W-1:0] nextCnt;

      assign nextCnt = {1'b0, runCnt} + CMP_W'(1);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          runCnt <= '0;
          levelQ <= 1'b0;
        end else if (strobe.bypassAll || !cfgMask[i]) begin
          runCnt <= '0;
          levelQ <= syncQ[i];
        end else if (syncQ[i] == levelQ) begin
          runCnt <= '0;
        end else if (strobe.tick) begin
          if (nextCnt >= {1'b0, cfgInterval}) begin
            runCnt <= '0;
            levelQ <= syncQ[i];
          end else begin
            runCnt <= nextCnt[IVL_W-1:0];
          end
        end
      end

      assign filtOut[i] = levelQ;
    end
  endgenerate
endmodule

// File: rtl/input_glitch_filter.sv
module input_glitch_filter
  import glitch_filter_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int TICK_DIV  = 10,
  localparam int BITS     = NUM_PORTS * PORT_BITS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [BITS-1:0]  rawIn,
  input  logic [IVL_W-1:0] cfgInterval,
  input  logic [BITS-1:0]  cfgMask,
  output logic [BITS-1:0]  filtOut
);
  gf_strobe_t      strobe;
  logic [BITS-1:0] syncQ;

  glitch_filter_ctrl #(.TICK_DIV(TICK_DIV)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgInterval(cfgInterval),
    .strobe     (strobe)
  );

  glitch_filter_datapath #(.BITS(BITS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rawIn      (rawIn),
    .cfgMask    (cfgMask),
    .cfgInterval(cfgInterval),
    .strobe     (strobe),
    .syncQ      (syncQ),
    .filtOut    (filtOut)
  );
endmodule

// File: rtl/glitch_filter_checker.sv
module glitch_filter_checker
  import glitch_filter_pkg::*;
#(
  parameter int BITS = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [BITS-1:0]  rawIn,
  input logic [IVL_W-1:0] cfgInterval,
  input logic [BITS-1:0]  cfgMask,
  input logic [BITS-1:0]  filtOut,
  input logic [BITS-1:0]  syncQ,
  input gf_strobe_t       strobe
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (!rstN) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  p_sync_delay_r2: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3) |-> (syncQ == $past(rawIn, 2)));

  generate
    for (genvar i = 0; i < BITS; i++) begin : g_chk
      p_unmasked_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
        ((age == 2'd3) && $past(!cfgMask[i])) |-> (filtOut[i] == $past(rawIn[i], 3)));

      p_zero_bypass_r3: assert property (@(posedge clk) disable iff (!rstN)
        ((age == 2'd3) && $past(cfgInterval == '0)) |-> (filtOut[i] == $past(rawIn[i], 3)));

      p_tick_only_r5: assert property (@(posedge clk) disable iff (!rstN)
        ((age != 2'd0) && $past(cfgMask[i]) && $past(cfgInterval != '0)
         && (filtOut[i] != $past(filtOut[i]))) |-> $past(strobe.tick));

      p_new_level_r5: assert property (@(posedge clk) disable iff (!rstN)
        ((age != 2'd0) && (filtOut[i] != $past(filtOut[i])))
          |-> (filtOut[i] == $past(syncQ[i])));
    end
  endgenerate
endmodule

bind input_glitch_filter glitch_filter_checker #(.BITS(BITS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rawIn      (rawIn),
  .cfgInterval(cfgInterval),
  .cfgMask    (cfgMask),
  .filtOut    (filtOut),
  .syncQ      (syncQ),
  .strobe     (strobe)
);

// File: tb/input_glitch_filter_bench.sv
module input_glitch_filter_bench;
  localparam int NP   = 2;
  localparam int BITS = NP * 8;
  localparam int DIV  = 10;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [BITS-1:0] rawIn = '0;
  logic [19:0]     cfgInterval = '0;
  logic [BITS-1:0] cfgMask = '0;
  logic [BITS-1:0] filtOut;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  input_glitch_filter #(.NUM_PORTS(NP), .TICK_DIV(DIV)) u_input_glitch_filter (
    .clk(clk), .rstN(rstN), .rawIn(rawIn),
    .cfgInterval(cfgInterval), .cfgMask(cfgMask), .filtOut(filtOut)
  );

  task automatic check(input bit ok, input string req, input int act,
                       input int expLo, input int expHi);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, expLo, expHi);
    end
  endtask

  // count edges until filtOut[b] reaches want (raw changed just after a negedge)
  task automatic waitLevel(input int b, input logic want, input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (filtOut[b] !== want && n < limit);
  endtask

  task automatic settle();
    rawIn = '0; cfgMask = '0; cfgInterval = '0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0..0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int n;
    int lo;
    int hi;
    int bad;
    // R1: reset holds outputs at zero even with all raw bits high
    rawIn = '1;
    repeat (5) @(negedge clk);
    check(filtOut == '0, "R1 in reset", int'(filtOut), 0, 0);
    rawIn = '0;
    rstN = 1'b1;
    @(negedge clk);
    check(filtOut == '0, "R1 after reset", int'(filtOut), 0, 0);
    settle();

    // R3: zero interval bypasses every bit even when fully masked
    cfgMask = '1; cfgInterval = '0;
    @(negedge clk);
    for (int b = 0; b < BITS; b++) begin
      rawIn[b] = 1'b1;
      waitLevel(b, 1'b1, 20, n);
      check(n == 3, $sformatf("R3 rise bit %0d", b), n, 3, 3);
      rawIn[b] = 1'b0;
      waitLevel(b, 1'b0, 20, n);
      check(n == 3, $sformatf("R3 fall bit %0d", b), n, 3, 3);
    end
    settle();

    // R2 / R9: single unmasked bit follows with three edges of latency
    cfgInterval = 20'd3;
    for (int b = 0; b < BITS; b++) begin
      cfgMask = '1;
      cfgMask[b] = 1'b0;
      @(negedge clk);
      rawIn[b] = 1'b1;
      waitLevel(b, 1'b1, 20, n);
      check(n == 3 && filtOut == (BITS'(1) << b), $sformatf("R2 R9 unmasked bit %0d", b), n, 3, 3);
      rawIn[b] = 1'b0;
      waitLevel(b, 1'b0, 20, n);
      check(n == 3, $sformatf("R2 unmasked fall bit %0d", b), n, 3, 3);
    end
    settle();

    // R4 / R9: filtered latency window for every bit and intervals 1..3
    for (int iv = 1; iv <= 3; iv++) begin
      lo = 3 + (iv - 1) * DIV;
      hi = 2 + iv * DIV;
      for (int b = 0; b < BITS; b++) begin
        cfgInterval = 20'(iv);
        cfgMask = BITS'(1) << b;
        @(negedge clk);
        rawIn[b] = 1'b1;
        waitLevel(b, 1'b1, hi + 10, n);
        check(n >= lo && n <= hi && filtOut[b] === 1'b1,
              $sformatf("R4 R9 rise bit %0d N=%0d", b, iv), n, lo, hi);
        rawIn[b] = 1'b0;
        waitLevel(b, 1'b0, hi + 10, n);
        check(n >= lo && n <= hi && filtOut[b] === 1'b0,
              $sformatf("R4 fall bit %0d N=%0d", b, iv), n, lo, hi);
      end
    end
    settle();

    // R6: pulse of (N-1)*DIV cycles never reaches the output
    for (int iv = 2; iv <= 3; iv++) begin
      cfgInterval = 20'(iv);
      cfgMask = 16'h0020;
      @(negedge clk);
      rawIn[5] = 1'b1;
      repeat ((iv - 1) * DIV) @(negedge clk);
      rawIn[5] = 1'b0;
      bad = 0;
      repeat (3 * iv * DIV) begin
        @(negedge clk);
        if (filtOut[5] !== 1'b0) bad++;
      end
      check(bad == 0, $sformatf("R6 pulse rejected N=%0d", iv), bad, 0, 0);
      settle();
    end

    // R7: short pulse, one-cycle return, then steady level needs full latency
    cfgInterval = 20'd3;
    cfgMask = 16'h0400;
    @(negedge clk);
    rawIn[10] = 1'b1;
    repeat (2 * DIV) @(negedge clk);
    rawIn[10] = 1'b0;
    @(negedge clk);
    rawIn[10] = 1'b1;
    waitLevel(10, 1'b1, 60, n);
    check(n >= 3 + 2 * DIV && n <= 2 + 3 * DIV, "R7 restart after reversion", n,
          3 + 2 * DIV, 2 + 3 * DIV);
    settle();

    // R8: bit 0 filtered, bit 9 unmasked, both rise together
    cfgInterval = 20'd3;
    cfgMask = 16'h0001;
    @(negedge clk);
    rawIn[0] = 1'b1;
    rawIn[9] = 1'b1;
    repeat (3) @(negedge clk);
    check(filtOut == 16'h0200, "R8 unmasked neighbour not delayed", int'(filtOut), 'h200, 'h200);
    waitLevel(0, 1'b1, 40, n);
    check(filtOut == 16'h0201 && n >= 2 * DIV && n <= 3 * DIV - 1, "R8 filtered bit completes",
          n + 3, 3 + 2 * DIV, 2 + 3 * DIV);
    settle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule